// File: doc/BRIEF.md
# Level-2 Cache Controller Stand-in Register Bank

This block is a register bank that sits where a level-2 cache controller would be, so that system software can probe, configure and "maintain" a cache that is not actually present. It answers a zero-wait-state APB-style 32-bit slave port. The decode covers a 4 KB window that repeats across the rest of the address space. It keeps the configuration registers that software expects to find: control, auxiliary control, tag and data RAM latency, and a pair of address-filter bounds. Reads of the whole maintenance-operation range return zero, so every clean, invalidate or sync operation appears to finish at once.

Reading the cache-type register has a side effect. Size fields are taken from the auxiliary control register and ORed into the stored cache-type word. That word only ever gains bits, so the value returned builds up over successive reads. Accesses to offsets that hold nothing still complete normally on the bus. Each one raises a single-cycle flag on a side output that debug logic can count.

Top module: `cstub_top`

## Requirements
- R1: Only address bits [11:0] are decoded. An access at any address gives the same result as an access at that address with bits above 11 cleared.
- R2: Offset 0x000 always reads 0x410000C8 (parameter ID_VALUE). A write to it changes nothing.
- R3: Every offset from 0x730 to 0x7FF inclusive reads 0. Writes there change no register, and these offsets do not raise the unmapped flag.
- R4: The control register at 0x100 stores only bit 0 of the written data. Bits [31:1] of a control read are always 0.
- R5: Offsets 0x104 (auxiliary), 0x108 (tag latency), 0x10C (data latency), 0xC00 (filter low) and 0xC04 (filter high) are full 32-bit read/write registers that return the last value written.
- R6: After reset, auxiliary control holds 0x02020000. Control, tag latency, data latency and both filter registers hold 0.
- R7: The cache-type word at 0x004 starts at parameter CTYPE_INIT (0x1C100100). On each read, let f = {aux[19:17], 1'b0, aux[16]}. The read returns stored | (f<<18) | (f<<6), and that result becomes the new stored value. The word changes on no other event.
- R8: Offsets 0xF40, 0xF60 and 0xF80 read 0. Writes to them change nothing, and they do not raise the unmapped flag.
- R9: Any other offset reads 0 and ignores writes. An access there drives `unmapped_pulse` high for exactly the one cycle after the access-phase edge. `pslverr` stays 0.
- R10: `pready` is always 1. Read data is valid throughout the access phase of a read. A write takes effect at the clock edge where psel, penable and pwrite are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Always 1 (no wait states) |
| pslverr | output | 1 | Always 0 |
| unmapped_pulse | output | 1 | One-cycle flag after an access to an unmapped offset |

## Verification
Read data is loaded at the setup-phase edge, so the bench samples `prdata` at the falling edge inside the access phase. The cache-type word and the write registers change at the access-phase edge, so their effect is first visible on the next transfer. `unmapped_pulse` is registered from the access-phase edge. The bench therefore samples it at the falling edge just after that edge, and again one cycle later to confirm that it has dropped. Every transfer the bench drives follows this same four-falling-edge schedule, so every sampling point is fixed relative to the stimulus.

// File: rtl/cstub_pkg.sv
package cstub_pkg;

   localparam int WIN_BITS = 12;
   localparam int DW       = 32;
   localparam int NUM_RW   = 5;   // aux, tag lat, data lat, filter lo, filter hi
   localparam int IDX_W    = $clog2(NUM_RW);

   typedef enum logic [2:0] {
      RS_ID,
      RS_CTYPE,
      RS_CTRL,
      RS_RW,
      RS_QUIET,
      RS_BAD
   } rsel_e;

   // Size-field merge term for the cache-type word
   function automatic logic [DW-1:0] ctype_mask(input logic [DW-1:0] aux);
      logic [4:0]    f;
      logic [DW-1:0] m;
      f       = {aux[19:17], 1'b0, aux[16]};
      m       = '0;
      m[22:18] = f;
      m[10:6]  = f;
      return m;
   endfunction

endpackage

// File: rtl/cstub_decode.sv
module cstub_decode
   import cstub_pkg::*;
#(
   parameter int                    ADDR_W   = 32,
   parameter logic [WIN_BITS-1:0]   MAINT_LO = 12'h730,
   parameter logic [WIN_BITS-1:0]   MAINT_HI = 12'h7FF
) (
   input  logic [ADDR_W-1:0] paddr,
   output rsel_e             sel,
   output logic [IDX_W-1:0]  rw_idx
);

   logic [WIN_BITS-1:0] off;

   assign off = paddr[WIN_BITS-1:0];

   always_comb begin
      sel    = RS_BAD;
      rw_idx = '0;
      if (off >= MAINT_LO && off <= MAINT_HI) begin
         sel = RS_QUIET;
      end else begin
         unique case (off)
            12'h000: sel = RS_ID;
            12'h004: sel = RS_CTYPE;
            12'h100: sel = RS_CTRL;
            12'h104: begin sel = RS_RW; rw_idx = IDX_W'(0); end
            12'h108: begin sel = RS_RW; rw_idx = IDX_W'(1); end
            12'h10C: begin sel = RS_RW; rw_idx = IDX_W'(2); end
            12'hC00: begin sel = RS_RW; rw_idx = IDX_W'(3); end
            12'hC04: begin sel = RS_RW; rw_idx = IDX_W'(4); end
            12'hF40, 12'hF60, 12'hF80: sel = RS_QUIET;
            default: sel = RS_BAD;
         endcase
      end
   end

endmodule

// File: rtl/cstub_regs.sv
module cstub_regs
   import cstub_pkg::*;
#(
   parameter logic [DW-1:0] AUX_RST    = 32'h0202_0000,
   parameter logic [DW-1:0] CTYPE_INIT = 32'h1C10_0100
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic                      rd_commit,
   input  rsel_e                     sel,
   input  logic [IDX_W-1:0]          rw_idx,
   input  logic [DW-1:0]             wdata,
   output logic [NUM_RW-1:0][DW-1:0] rw_vals,
   output logic                      ctrl_bit,
   output logic [DW-1:0]             ctype_next
);

   logic [DW-1:0] rw_q [NUM_RW];
   logic [DW-1:0] ctype_q;
   logic          ctrl_q;

   generate
      for (genvar g = 0; g < NUM_RW; g++) begin : g_rw
         localparam logic [DW-1:0] RV = (g == 0) ? AUX_RST : '0;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               rw_q[g] <= RV;
            else if (wr_en && sel == RS_RW && rw_idx == IDX_W'(g))
               rw_q[g] <= wdata;
         end
         assign rw_vals[g] = rw_q[g];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctrl_q <= 1'b0;
      else if (wr_en && sel == RS_CTRL)
         ctrl_q <= wdata[0];
   end

   assign ctype_next = ctype_q | ctype_mask(rw_q[0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctype_q <= CTYPE_INIT;
      else if (rd_commit && sel == RS_CTYPE)
         ctype_q <= ctype_next;
   end

   assign ctrl_bit = ctrl_q;

   // R7
   ctype_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((ctype_q & $past(ctype_q)) == $past(ctype_q)));

   // R7
   ctype_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_commit && sel == RS_CTYPE) |=> $stable(ctype_q));

   // R4
   ctrl_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel == RS_CTRL) |=> (ctrl_q == $past(wdata[0])));

   // R3 R8 R9
   quiet_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (sel == RS_QUIET || sel == RS_BAD || sel == RS_ID))
      |=> ($stable(rw_vals) && $stable(ctrl_q)));

endmodule

// File: rtl/cstub_resp.sv
module cstub_resp
   import cstub_pkg::*;
#(
   parameter logic [DW-1:0] ID_VALUE = 32'h4100_00C8,
   parameter bit            ERR_REG  = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      setup_rd,
   input  logic                      acc,
   input  rsel_e                     sel,
   input  logic [IDX_W-1:0]          rw_idx,
   input  logic [NUM_RW-1:0][DW-1:0] rw_vals,
   input  logic                      ctrl_bit,
   input  logic [DW-1:0]             ctype_next,
   output logic [DW-1:0]             prdata,
   output logic                      err_pulse
);

   logic [DW-1:0] rd_val;
   logic [DW-1:0] prdata_q;

   always_comb begin
      case (sel)
         RS_ID:    rd_val = ID_VALUE;
         RS_CTYPE: rd_val = ctype_next;
         RS_CTRL:  rd_val = {{(DW-1){1'b0}}, ctrl_bit};
         RS_RW:    rd_val = rw_vals[rw_idx];
         default:  rd_val = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         prdata_q <= '0;
      else if (setup_rd)
         prdata_q <= rd_val;
   end

   assign prdata = prdata_q;

   generate
      if (ERR_REG) begin : g_err_reg
         logic err_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               err_q <= 1'b0;
            else
               err_q <= acc && sel == RS_BAD;
         end
         assign err_pulse = err_q;

         // R9
         err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (acc && sel == RS_BAD) |=> err_pulse);

         // R9
         err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(acc && sel == RS_BAD) |=> !err_pulse);
      end else begin : g_err_comb
         assign err_pulse = acc && sel == RS_BAD;
      end
   endgenerate

endmodule

// File: rtl/cstub_top.sv
module cstub_top
   import cstub_pkg::*;
#(
   parameter int            ADDR_W     = 32,
   parameter logic [DW-1:0] ID_VALUE   = 32'h4100_00C8,
   parameter logic [DW-1:0] CTYPE_INIT = 32'h1C10_0100,
   parameter logic [DW-1:0] AUX_RST    = 32'h0202_0000,
   parameter bit            ERR_REG    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [31:0]       pwdata,
   output logic [31:0]       prdata,
   output logic              pready,
   output logic              pslverr,
   output logic              unmapped_pulse
);

   generate
      if (ADDR_W < WIN_BITS) begin : g_bad_aw
         $error("cstub_top: ADDR_W must cover the 12-bit window");
      end
      if (ADDR_W > 64) begin : g_big_aw
         $error("cstub_top: ADDR_W above 64 is not supported");
      end
   endgenerate

   logic                      setup_rd, acc, wr_en, rd_commit;
   rsel_e                     sel;
   logic [IDX_W-1:0]          rw_idx;
   logic [NUM_RW-1:0][DW-1:0] rw_vals;
   logic                      ctrl_bit;
   logic [DW-1:0]             ctype_next;

   assign setup_rd  = psel && !penable && !pwrite;
   assign acc       = psel && penable;
   assign wr_en     = acc && pwrite;
   assign rd_commit = acc && !pwrite;

   cstub_decode #(.ADDR_W(ADDR_W)) u_dec (
      .paddr  (paddr),
      .sel    (sel),
      .rw_idx (rw_idx)
   );

   cstub_regs #(.AUX_RST(AUX_RST), .CTYPE_INIT(CTYPE_INIT)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .rd_commit  (rd_commit),
      .sel        (sel),
      .rw_idx     (rw_idx),
      .wdata      (pwdata),
      .rw_vals    (rw_vals),
      .ctrl_bit   (ctrl_bit),
      .ctype_next (ctype_next)
   );

   cstub_resp #(.ID_VALUE(ID_VALUE), .ERR_REG(ERR_REG)) u_resp (
      .clk        (clk),
      .rst_n      (rst_n),
      .setup_rd   (setup_rd),
      .acc        (acc),
      .sel        (sel),
      .rw_idx     (rw_idx),
      .rw_vals    (rw_vals),
      .ctrl_bit   (ctrl_bit),
      .ctype_next (ctype_next),
      .prdata     (prdata),
      .err_pulse  (unmapped_pulse)
   );

   assign pready  = 1'b1;
   assign pslverr = 1'b0;

   // R2
   id_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (setup_rd && paddr[11:0] == 12'h000) |=> (prdata == ID_VALUE));

   // R3
   maint_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (setup_rd && paddr[11:0] >= 12'h730 && paddr[11:0] <= 12'h7FF) |=> (prdata == '0));

   // R4
   ctrl_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (setup_rd && paddr[11:0] == 12'h100) |=> (prdata[31:1] == '0));

endmodule

// File: tb/sim_cstub_top.sv
`timescale 1ns/1ps
module sim_cstub_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [31:0] paddr = '0, pwdata = '0;
   logic [31:0] prdata;
   logic        pready, pslverr, unmapped_pulse;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   cstub_top u0 (
      .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
      .pslverr(pslverr), .unmapped_pulse(unmapped_pulse)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   // Four-falling-edge transfer: setup, access, pulse sample, pulse-drop sample
   task automatic xfer(input logic wr, input logic [31:0] a, input logic [31:0] d,
                       output logic [31:0] rd, output logic e1, output logic e2);
      @(negedge clk);
      psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
      @(negedge clk);
      penable = 1'b1;
      rd = prdata;
      chk("R10 pready", {31'b0, pready}, 32'd1);
      @(negedge clk);
      e1 = unmapped_pulse;
      chk("R9 pslverr", {31'b0, pslverr}, 32'd0);
      psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
      @(negedge clk);
      e2 = unmapped_pulse;
   endtask

   task automatic wr(input logic [31:0] a, input logic [31:0] d);
      logic [31:0] r; logic e1, e2;
      xfer(1'b1, a, d, r, e1, e2);
   endtask

   task automatic rd_chk(input string req, input logic [31:0] a, input logic [31:0] exp);
      logic [31:0] r; logic e1, e2;
      xfer(1'b0, a, 32'h0, r, e1, e2);
      chk(req, r, exp);
   endtask

   function automatic logic [31:0] ct_mask(input logic [31:0] aux);
      int f;
      f = (((aux >> 17) & 7) << 2) | ((aux >> 16) & 1);
      return 32'((f << 18) | (f << 6));
   endfunction

   logic [31:0] ct_model = 32'h1C10_0100;
   logic [31:0] aux_model = 32'h0202_0000;

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_err++; n_chk++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      logic [31:0] r; logic e1, e2;
      logic [31:0] rw_offs [5];
      rw_offs[0] = 32'h104; rw_offs[1] = 32'h108; rw_offs[2] = 32'h10C;
      rw_offs[3] = 32'hC00; rw_offs[4] = 32'hC04;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R6 reset values
      chk("R6 prdata reset", prdata, 32'h0);
      chk("R9 pulse reset", {31'b0, unmapped_pulse}, 32'h0);
      rd_chk("R6 aux reset", 32'h104, 32'h0202_0000);
      rd_chk("R6 ctrl reset", 32'h100, 32'h0);
      for (int i = 1; i < 5; i++) rd_chk("R6 rw reset", rw_offs[i], 32'h0);

      // R7 initial read
      ct_model = ct_model | ct_mask(aux_model);
      rd_chk("R7 ctype first", 32'h004, ct_model);

      // R2 id, with write ignored
      rd_chk("R2 id", 32'h000, 32'h4100_00C8);
      wr(32'h000, 32'hDEAD_BEEF);
      rd_chk("R2 id after write", 32'h000, 32'h4100_00C8);

      // R4 control
      wr(32'h100, 32'hFFFF_FFFF);
      rd_chk("R4 ctrl all ones", 32'h100, 32'h1);
      wr(32'h100, 32'hFFFF_FFFE);
      rd_chk("R4 ctrl bit0 clear", 32'h100, 32'h0);
      wr(32'h100, 32'h0000_0003);
      rd_chk("R4 ctrl bit0 set", 32'h100, 32'h1);

      // R5 read/write registers, several patterns
      for (int p = 0; p < 3; p++) begin
         for (int i = 0; i < 5; i++) begin
            logic [31:0] v;
            v = (p == 0) ? 32'hFFFF_FFFF : (p == 1) ? 32'h0 : (32'hA5A5_0000 ^ (i * 32'h1111_1111));
            wr(rw_offs[i], v);
            rd_chk("R5 rw readback", rw_offs[i], v);
         end
      end

      // R1 aliasing above bit 11
      wr(32'h0000_1108, 32'h1234_5678);
      rd_chk("R1 alias read 0x108", 32'h108, 32'h1234_5678);
      rd_chk("R1 alias read high", 32'hFFFF_F108, 32'h1234_5678);
      rd_chk("R1 alias id", 32'hABCD_E000, 32'h4100_00C8);

      // R7 sweep of aux[19:16], cache-type accumulates
      for (int k = 0; k < 16; k++) begin
         aux_model = 32'h5A00_0000 | (32'(k) << 16);
         wr(32'h104, aux_model);
         ct_model = ct_model | ct_mask(aux_model);
         rd_chk("R7 ctype accumulate", 32'h004, ct_model);
         rd_chk("R7 ctype persists", 32'h1004, ct_model);
      end

      // R3 maintenance range, writes ignored, no flag
      wr(32'h104, 32'h0BAD_F00D);
      for (int o = 'h730; o <= 'h7FC; o += 4) begin
         xfer(1'b1, 32'(o), 32'hFFFF_FFFF, r, e1, e2);
         chk("R3 maint write no flag", {31'b0, e1}, 32'h0);
         xfer(1'b0, 32'(o), 32'h0, r, e1, e2);
         chk("R3 maint reads zero", r, 32'h0);
         chk("R3 maint read no flag", {31'b0, e1}, 32'h0);
      end
      rd_chk("R3 maint writes ignored", 32'h104, 32'h0BAD_F00D);
      rd_chk("R3 ctrl untouched", 32'h100, 32'h1);
      xfer(1'b0, 32'h7FF, 32'h0, r, e1, e2);
      chk("R3 maint top byte", r, 32'h0);

      // R8 fixed-zero offsets
      for (int j = 0; j < 3; j++) begin
         logic [31:0] a;
         a = 32'hF40 + 32'(j) * 32'h20;
         xfer(1'b1, a, 32'hFFFF_FFFF, r, e1, e2);
         chk("R8 write no flag", {31'b0, e1}, 32'h0);
         xfer(1'b0, a, 32'h0, r, e1, e2);
         chk("R8 reads zero", r, 32'h0);
         chk("R8 read no flag", {31'b0, e1}, 32'h0);
      end
      rd_chk("R8 aux untouched", 32'h104, 32'h0BAD_F00D);

      // R9 unmapped offsets
      for (int j = 0; j < 6; j++) begin
         logic [31:0] a;
         case (j)
            0: a = 32'h008; 1: a = 32'h10E; 2: a = 32'h110;
            3: a = 32'h72C; 4: a = 32'hC08; default: a = 32'hFFC;
         endcase
         xfer(1'b1, a, 32'hFFFF_FFFF, r, e1, e2);
         chk("R9 write pulse high", {31'b0, e1}, 32'h1);
         chk("R9 write pulse one cycle", {31'b0, e2}, 32'h0);
         xfer(1'b0, a, 32'h0, r, e1, e2);
         chk("R9 read zero", r, 32'h0);
         chk("R9 read pulse high", {31'b0, e1}, 32'h1);
         chk("R9 read pulse one cycle", {31'b0, e2}, 32'h0);
      end
      rd_chk("R9 aux untouched", 32'h104, 32'h0BAD_F00D);
      rd_chk("R9 filter hi untouched", 32'hC04, 32'hA5A5_0000 ^ (32'd4 * 32'h1111_1111));
      rd_chk("R9 ctrl untouched", 32'h100, 32'h1);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule